// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block picks the settings for a pixel clock source made of a PLL and a post-divider. The PLL runs at `n` times a 3 MHz base step. Its output is used either as it is or doubled, and then divided by `m`. A caller gives a target frequency in kHz and picks one of two output channels. Each channel allows its own range of `m`. The block then walks through that range one `m` at a time.

For each `m` it tests a plain candidate, and for odd `m` also a doubled candidate. It keeps the setting that comes closest to the target without going over it. All quotients come from one shared multi-cycle divider. A whole search therefore takes many cycles: a few thousand for the wide channel and a few hundred for the narrow one.

Control uses plain pins with no back-pressure. `start` is taken only while `busy` is low. `done` pulses for one cycle when a search ends. The result registers change only in that cycle and hold their values until the next `done`.

Top module: `pixclk_div_search`

## Requirements
- R1: After reset, `busy`, `done`, `no_match`, `use_x2`, `pll_n`, `post_m` and `out_khz` are all 0.
- R2: With `chan_sel`=0 the divider `m` is searched over 6..127. With `chan_sel`=1 it is searched over 1..15. A reported `post_m` always lies in the range of the selected channel.
- R3: The plain candidate at `m` uses n = floor(m*f/3000). It counts only when 9 <= n <= 127, and its frequency is floor(3000*n/m) kHz.
- R4: The doubled candidate exists only for odd `m`. It uses n = floor(m*f/6000) with the same n limits, and its frequency is floor(6000*n/m) kHz. A chosen doubled candidate is reported with `use_x2`=1.
- R5: The reported setting has the smallest error (f minus candidate frequency). A candidate replaces the current best only when its error is strictly smaller. So on a tie the lowest `m` wins, and at the same `m` the plain candidate wins over the doubled one.
- R6: On a match, `out_khz` is never above `freq_khz`.
- R7: If no candidate is valid, `no_match`=1 and `pll_n`, `post_m`, `use_x2` and `out_khz` are 0.
- R8: `busy` rises in the cycle after `start` is accepted. `done` is a single-cycle pulse with `busy` low, given exactly once per accepted start.
- R9: A `start` that arrives while `busy` is high is ignored. The running search finishes on its original request, and no extra `done` follows.
- R10: The result outputs stay unchanged in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; taken only while idle |
| chan_sel | input | 1 | Channel: 0 selects m 6..127, 1 selects m 1..15 |
| freq_khz | input | 20 | Target frequency in kHz, sampled at start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse; results are updated |
| no_match | output | 1 | No valid candidate was found |
| pll_n | output | 7 | Chosen PLL multiplier n |
| post_m | output | 7 | Chosen post-divider m |
| use_x2 | output | 1 | Doubled PLL output selected |
| out_khz | output | 20 | Frequency reached by the chosen setting, in kHz |

## Verification
An internal fault stays hidden until the search ends. Examples are a wrong divider quotient, a skipped or repeated `m`, or a best-so-far register that takes a tie. Each of these shows up only as a different `pll_n`, `post_m`, `use_x2` or `out_khz` in the single `done` cycle. That can be thousands of cycles after `start`.

The stimulus therefore mixes exact-hit targets, where ties decide the answer, with targets that yield no match and with random targets on both channels. Every reported field is compared with a model of the search. A state-machine fault that leaves the search stuck instead shows at the ports as `busy` that never falls.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NQ,
    ST_NV,
    ST_DQ,
    ST_DV,
    ST_STEP,
    ST_FIN
  } pds_state_e;
endpackage

// File: rtl/pds_iter_div.sv
module pds_iter_div #(
  parameter int NUM_W = 27,
  parameter int DEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo,
  output logic [DEN_W-1:0] rem
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam int CHK_W = NUM_W + DEN_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [NUM_W-1:0] num_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W:0]   shifted;
  logic             fits;

  assign shifted = {rem, quo[NUM_W-1]};
  assign fits    = shifted >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      quo   <= '0;
      rem   <= '0;
      cnt   <= '0;
      num_q <= '0;
      den_q <= '0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        quo   <= num;
        rem   <= '0;
        num_q <= num;
        den_q <= den;
        cnt   <= CNT_W'(NUM_W);
        busy  <= 1'b1;
      end else if (busy) begin
        if (fits) rem <= DEN_W'(shifted - {1'b0, den_q});
        else      rem <= shifted[DEN_W-1:0];
        quo <= {quo[NUM_W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R3: a finished division is exact: quo*den + rem == num and rem < den
  a_r3_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((CHK_W'(quo) * CHK_W'(den_q) + CHK_W'(rem)) == CHK_W'(num_q)) && (rem < den_q));
endmodule

// File: rtl/pds_best_keep.sv
module pds_best_keep #(
  parameter int M_W    = 7,
  parameter int FREQ_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cand_vld,
  input  logic [FREQ_W:0]   cand_err,
  input  logic [M_W-1:0]    cand_n,
  input  logic [M_W-1:0]    cand_m,
  input  logic              cand_dbl,
  input  logic [FREQ_W-1:0] cand_khz,
  output logic              best_vld,
  output logic [M_W-1:0]    best_n,
  output logic [M_W-1:0]    best_m,
  output logic              best_dbl,
  output logic [FREQ_W-1:0] best_khz
);
  localparam int ERR_W = FREQ_W + 1;
  logic [ERR_W-1:0] best_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_err <= '1;
      best_vld <= 1'b0;
      best_n   <= '0;
      best_m   <= '0;
      best_dbl <= 1'b0;
      best_khz <= '0;
    end else if (clr) begin
      best_err <= '1;
      best_vld <= 1'b0;
    end else if (cand_vld && (cand_err < best_err)) begin
      best_err <= cand_err;
      best_vld <= 1'b1;
      best_n   <= cand_n;
      best_m   <= cand_m;
      best_dbl <= cand_dbl;
      best_khz <= cand_khz;
    end
  end

  // R5: without a clear, the best error can only shrink or stay
  a_r5_err_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (best_err <= $past(best_err)));
  // R5: an equal error never replaces the best setting
  a_r5_tie_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cand_vld && best_vld && (cand_err == best_err)) |=> $stable(best_m) && $stable(best_dbl));
endmodule

// File: rtl/pixclk_div_search.sv
module pixclk_div_search #(
  parameter int FREQ_W   = 20,
  parameter int M_W      = 7,
  parameter int N_MIN    = 9,
  parameter int N_MAX    = 127,
  parameter int CH0_M_LO = 6,
  parameter int CH0_M_HI = 127,
  parameter int CH1_M_LO = 1,
  parameter int CH1_M_HI = 15,
  parameter int BASE_KHZ = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chan_sel,
  input  logic [FREQ_W-1:0] freq_khz,
  output logic              busy,
  output logic              done,
  output logic              no_match,
  output logic [M_W-1:0]    pll_n,
  output logic [M_W-1:0]    post_m,
  output logic              use_x2,
  output logic [FREQ_W-1:0] out_khz
);
  import pds_pkg::*;

  localparam int NUM_W = M_W + FREQ_W;
  localparam int DEN_W = $clog2(2 * BASE_KHZ + 1);
  localparam int ERR_W = FREQ_W + 1;

  pds_state_e        state;
  logic [FREQ_W-1:0] f_q;
  logic              ch_q;
  logic [M_W-1:0]    m_q;
  logic [M_W-1:0]    cand_n_q;
  logic              go_q;

  logic [NUM_W-1:0]  div_num;
  logic [DEN_W-1:0]  div_den;
  logic              div_busy, div_done;
  logic [NUM_W-1:0]  div_quo;
  logic [DEN_W-1:0]  div_rem;

  logic              n_ok, m_odd, m_last, accept, cand_vld;
  logic [M_W-1:0]    m_first, m_hi_cur;
  logic [ERR_W-1:0]  cand_err;
  logic              best_vld, best_dbl;
  logic [M_W-1:0]    best_n, best_m;
  logic [FREQ_W-1:0] best_khz;

  assign busy     = (state != ST_IDLE);
  assign accept   = (state == ST_IDLE) && start;
  assign m_first  = chan_sel ? M_W'(CH1_M_LO) : M_W'(CH0_M_LO);
  assign m_hi_cur = ch_q ? M_W'(CH1_M_HI) : M_W'(CH0_M_HI);
  assign m_odd    = m_q[0];
  assign m_last   = (m_q == m_hi_cur);
  assign n_ok     = (div_quo >= NUM_W'(N_MIN)) && (div_quo <= NUM_W'(N_MAX));

  // divider operand selection per search phase
  always_comb begin
    div_num = NUM_W'(m_q) * NUM_W'(f_q);
    div_den = DEN_W'(BASE_KHZ);
    unique case (state)
      ST_NV: begin
        div_num = NUM_W'(BASE_KHZ) * NUM_W'(cand_n_q);
        div_den = DEN_W'(m_q);
      end
      ST_DQ: div_den = DEN_W'(2 * BASE_KHZ);
      ST_DV: begin
        div_num = NUM_W'(2 * BASE_KHZ) * NUM_W'(cand_n_q);
        div_den = DEN_W'(m_q);
      end
      default: ;
    endcase
  end

  assign cand_vld = div_done && ((state == ST_NV) || (state == ST_DV));
  assign cand_err = {1'b0, f_q} - {1'b0, div_quo[FREQ_W-1:0]};

  pds_iter_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(go_q), .num(div_num), .den(div_den),
    .busy(div_busy), .done(div_done), .quo(div_quo), .rem(div_rem)
  );

  pds_best_keep #(.M_W(M_W), .FREQ_W(FREQ_W)) u_best (
    .clk(clk), .rst_n(rst_n), .clr(accept), .cand_vld(cand_vld),
    .cand_err(cand_err), .cand_n(cand_n_q), .cand_m(m_q),
    .cand_dbl(state == ST_DV), .cand_khz(div_quo[FREQ_W-1:0]),
    .best_vld(best_vld), .best_n(best_n), .best_m(best_m),
    .best_dbl(best_dbl), .best_khz(best_khz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      f_q      <= '0;
      ch_q     <= 1'b0;
      m_q      <= '0;
      cand_n_q <= '0;
      go_q     <= 1'b0;
      done     <= 1'b0;
      no_match <= 1'b0;
      pll_n    <= '0;
      post_m   <= '0;
      use_x2   <= 1'b0;
      out_khz  <= '0;
    end else begin
      go_q <= 1'b0;
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          f_q   <= freq_khz;
          ch_q  <= chan_sel;
          m_q   <= m_first;
          go_q  <= 1'b1;
          state <= ST_NQ;
        end
        ST_NQ, ST_DQ: if (div_done) begin
          if (n_ok) begin
            cand_n_q <= div_quo[M_W-1:0];
            go_q     <= 1'b1;
            state    <= (state == ST_NQ) ? ST_NV : ST_DV;
          end else if ((state == ST_NQ) && m_odd) begin
            go_q  <= 1'b1;
            state <= ST_DQ;
          end else begin
            state <= ST_STEP;
          end
        end
        ST_NV: if (div_done) begin
          if (m_odd) begin
            go_q  <= 1'b1;
            state <= ST_DQ;
          end else begin
            state <= ST_STEP;
          end
        end
        ST_DV: if (div_done) state <= ST_STEP;
        ST_STEP: begin
          if (m_last) begin
            state <= ST_FIN;
          end else begin
            m_q   <= m_q + 1'b1;
            go_q  <= 1'b1;
            state <= ST_NQ;
          end
        end
        ST_FIN: begin
          done     <= 1'b1;
          no_match <= !best_vld;
          pll_n    <= best_vld ? best_n : '0;
          post_m   <= best_vld ? best_m : '0;
          use_x2   <= best_vld && best_dbl;
          out_khz  <= best_vld ? best_khz : '0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: done lasts one cycle and never overlaps busy
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8: an accepted start raises busy in the next cycle
  a_r8_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R9: the sampled request does not change during a search
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(f_q) && $stable(ch_q));
  // R6: a match never exceeds the request
  a_r6_not_above: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_match) |-> (out_khz <= f_q));
  // R2: a reported m lies inside the channel range
  a_r2_m_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_match) |-> (ch_q ? ((post_m >= M_W'(CH1_M_LO)) && (post_m <= M_W'(CH1_M_HI)))
                                  : ((post_m >= M_W'(CH0_M_LO)) && (post_m <= M_W'(CH0_M_HI)))));
  // R4: a doubled result always has an odd m
  a_r4_x2_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (done && use_x2) |-> post_m[0]);
  // R7: no match clears every result field
  a_r7_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_match) |-> (pll_n == '0) && (post_m == '0) && !use_x2 && (out_khz == '0));
  // R10: results change only with done
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pll_n) && $stable(post_m) && $stable(use_x2) && $stable(out_khz) && $stable(no_match));
endmodule

// File: tb/pixclk_div_search_test.sv
module pixclk_div_search_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        chan_sel = 1'b0;
  logic [19:0] freq_khz = '0;
  logic        busy, done, no_match, use_x2;
  logic [6:0]  pll_n, post_m;
  logic [19:0] out_khz;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pixclk_div_search uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .freq_khz(freq_khz), .busy(busy), .done(done), .no_match(no_match),
    .pll_n(pll_n), .post_m(post_m), .use_x2(use_x2), .out_khz(out_khz)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input int ch, input int f, output int bn, output int bm,
                                output int bd, output int bv, output int nm);
    int lo, hi, best, n, v;
    lo = ch ? 1 : 6;
    hi = ch ? 15 : 127;
    bn = 0; bm = 0; bd = 0; bv = 0; nm = 1; best = 32'h7fffffff;
    for (int m = lo; m <= hi; m++) begin
      n = (m * f) / 3000;
      if (n >= 9 && n <= 127) begin
        v = (3000 * n) / m;
        if (f - v < best) begin best = f - v; bn = n; bm = m; bd = 0; bv = v; nm = 0; end
      end
      if (m % 2 == 1) begin
        n = (m * f) / 6000;
        if (n >= 9 && n <= 127) begin
          v = (6000 * n) / m;
          if (f - v < best) begin best = f - v; bn = n; bm = m; bd = 1; bv = v; nm = 0; end
        end
      end
    end
  endfunction

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
  endtask

  task automatic run(input int ch, input int f, input string req);
    int bn, bm, bd, bv, nm;
    bit got;
    model(ch, f, bn, bm, bd, bv, nm);
    @(negedge clk);
    start = 1'b1; chan_sel = ch[0]; freq_khz = f[19:0];
    @(negedge clk);
    start = 1'b0;
    check("R8", "busy after start", int'(busy), 1);
    wait_done(got);
    check("R8", "done seen", int'(got), 1);
    check(req, "no_match", int'(no_match), nm);
    check(req, "pll_n", int'(pll_n), bn);
    check(req, "post_m", int'(post_m), bm);
    check(req, "use_x2", int'(use_x2), bd);
    check(req, "out_khz", int'(out_khz), bv);
    check("R8", "busy at done", int'(busy), 0);
    @(negedge clk);
    check("R8", "done one cycle", int'(done), 0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed, p_n, p_m;
    bit got;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "no_match", int'(no_match), 0);
    check("R1", "pll_n", int'(pll_n), 0);
    check("R1", "post_m", int'(post_m), 0);
    check("R1", "use_x2", int'(use_x2), 0);
    check("R1", "out_khz", int'(out_khz), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 exact hit at m=1: plain n=9 wins all later ties
    run(1, 27000, "R5");
    // R5 exact for both paths at m=1: plain wins
    run(1, 60000, "R5");
    // R3 R4 typical requests on both channels
    run(1, 25175, "R3");
    run(0, 25175, "R4");
    run(1, 148500, "R4");
    // R7 too low for channel 1, too high for channel 0
    run(1, 1000, "R7");
    run(0, 1000000, "R7");
    // R2 boundary: channel 0 lower end of n
    run(0, 4500, "R2");

    // R6 random requests
    for (int i = 0; i < 12; i++) run(1, int'($urandom_range(400000, 5000)), "R6");
    for (int i = 0; i < 3; i++) run(0, int'($urandom_range(63000, 1500)), "R6");

    // R9 a start while busy is ignored; R10 results hold
    run(1, 74250, "R9");
    p_n = int'(pll_n); p_m = int'(post_m);
    @(negedge clk);
    start = 1'b1; chan_sel = 1'b1; freq_khz = 20'd40000;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; chan_sel = 1'b0; freq_khz = 20'd9000;
    @(negedge clk);
    start = 1'b0;
    check("R10", "pll_n held during search", int'(pll_n), p_n);
    check("R10", "post_m held during search", int'(post_m), p_m);
    begin
      int bn, bm, bd, bv, nm;
      model(1, 40000, bn, bm, bd, bv, nm);
      wait_done(got);
      check("R9", "done seen", int'(got), 1);
      check("R9", "pll_n first request", int'(pll_n), bn);
      check("R9", "post_m first request", int'(post_m), bm);
      check("R9", "out_khz first request", int'(out_khz), bv);
      got = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (done) got = 1'b1;
      end
      check("R9", "no extra done", int'(got), 0);
      check("R10", "out_khz held idle", int'(out_khz), bv);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule